// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Status Flags

This block does the single-bit shift, rotate and nibble-swap steps of a byte-wide execution unit. Each accepted request carries an operand byte, the carry bit currently held in the status register, and a 3-bit operation code. One clock edge later the block presents the result byte, the new values of five status flags and a write-enable mask. The mask tells the status register which flags this operation changes. Flags outside the mask must be left alone.

The supported operations are logical shift left, logical shift right, rotate left through carry, rotate right through carry, arithmetic shift right and nibble swap. The incoming carry takes part only in the two rotates. The four shifts and rotates, plus the arithmetic shift, all send the bit that falls off the end into Carry. Nibble swap writes no flag at all.

The caller drives a request with `valid_i` high. The register stage raises `valid_o` for exactly one cycle per request and holds the last result while idle.

Top module: `byte_shift_unit`

## Requirements
- R1: The cycle after `valid_i` is high, `valid_o` is high and `result_o`, `flags_o` and `flag_we_o` reflect that request. After reset `valid_o`, `result_o`, `flags_o` and `flag_we_o` are all zero.
- R2: Op code 0 (shift left) gives result = operand shifted up one place with 0 entering bit 0. The new C is old operand bit 7.
- R3: Op code 1 (shift right) gives result = operand shifted down one place with 0 entering bit 7. The new C is old operand bit 0.
- R4: Op code 2 (rotate left) gives result = operand shifted up one place with `carry_i` entering bit 0. The new C is old operand bit 7.
- R5: Op code 3 (rotate right) gives result = operand shifted down one place with `carry_i` entering bit 7. The new C is old operand bit 0.
- R6: Op code 4 (arithmetic shift right) gives result = operand shifted down one place with bit 7 kept as it was. The new C is old operand bit 0.
- R7: Op code 5 (nibble swap) exchanges operand bits 7..4 with bits 3..0. Its `flag_we_o` and `flags_o` are both zero.
- R8: For op codes 0 to 4, the flags are set as follows. Z is 1 exactly when the result is zero. N equals result bit 7. V equals N XOR the new C.
- R9: For op codes 0 and 2, H equals old operand bit 3. For op codes 1, 3 and 4, H is not written.
- R10: Flag positions in `flags_o` and `flag_we_o` are C=bit 0, Z=bit 1, N=bit 2, V=bit 3, H=bit 4. `flag_we_o` is 5'b11111 for op codes 0 and 2, and 5'b01111 for op codes 1, 3 and 4. Any `flags_o` bit whose enable is 0 reads 0.
- R11: Op codes 6 and 7 pass the operand through unchanged. Their `flag_we_o` and `flags_o` are zero.
- R12: In a cycle after `valid_i` was low, `valid_o` and `flag_we_o` are 0, and `result_o` and `flags_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| operand_i | input | 8 | Operand byte |
| carry_i | input | 1 | Carry bit from the status register |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 8 | Result byte |
| flags_o | output | 5 | New flag values {H,V,N,Z,C} |
| flag_we_o | output | 5 | Per-flag write enable {H,V,N,Z,C} |

## Verification
The hardest cases to reach are those where the overflow flag depends on the carry produced by the same operation. Examples are a left shift of 0x80, which gives zero with C set and so V=1 with N=0, and an arithmetic shift of a negative odd value, where N and C are both 1 so V=0. The directed tasks drive these operands on purpose. They also drive both values of the incoming carry into each rotate. Back-to-back requests are issued on consecutive cycles to show that each result lands one cycle after its request. These are followed by an idle cycle to show that the mask drops while the data holds.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_ROTL = 3'd2,
    OP_ROTR = 3'd3,
    OP_SAR  = 3'd4,
    OP_SWAP = 3'd5
  } shift_op_e;

  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_H = 4;

  localparam logic [NUM_FLAGS-1:0] WE_LEFT  = 5'b11111;
  localparam logic [NUM_FLAGS-1:0] WE_RIGHT = 5'b01111;
  localparam logic [NUM_FLAGS-1:0] WE_NONE  = 5'b00000;
endpackage

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             half_o,
  output logic             is_left_o,
  output logic             is_right_o
);
  localparam int unsigned HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  // nibble swap built bit by bit so WIDTH stays generic
  for (genvar i = 0; i < WIDTH; i++) begin : g_swap
    if (i < HALF) begin : g_lo
      assign swapped[i] = operand_i[i+HALF];
    end else begin : g_hi
      assign swapped[i] = operand_i[i-HALF];
    end
  end

  assign half_o = operand_i[HALF-1];

  always_comb begin
    result_o   = operand_i;
    carry_o    = 1'b0;
    is_left_o  = 1'b0;
    is_right_o = 1'b0;
    case (shift_op_e'(op_i))
      OP_SHL: begin
        result_o  = {operand_i[WIDTH-2:0], 1'b0};
        carry_o   = operand_i[WIDTH-1];
        is_left_o = 1'b1;
      end
      OP_ROTL: begin
        result_o  = {operand_i[WIDTH-2:0], carry_i};
        carry_o   = operand_i[WIDTH-1];
        is_left_o = 1'b1;
      end
      OP_SHR: begin
        result_o   = {1'b0, operand_i[WIDTH-1:1]};
        carry_o    = operand_i[0];
        is_right_o = 1'b1;
      end
      OP_ROTR: begin
        result_o   = {carry_i, operand_i[WIDTH-1:1]};
        carry_o    = operand_i[0];
        is_right_o = 1'b1;
      end
      OP_SAR: begin
        result_o   = {operand_i[WIDTH-1], operand_i[WIDTH-1:1]};
        carry_o    = operand_i[0];
        is_right_o = 1'b1;
      end
      OP_SWAP: result_o = swapped;
      default: result_o = operand_i;
    endcase
  end
endmodule

// File: rtl/shift_flags.sv
module shift_flags
  import shift_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]     result_i,
  input  logic                 carry_i,
  input  logic                 half_i,
  input  logic                 is_left_i,
  input  logic                 is_right_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] we_o
);
  logic [NUM_FLAGS-1:0] raw;

  always_comb begin
    raw        = '0;
    raw[FLG_C] = carry_i;
    raw[FLG_Z] = ~|result_i;
    raw[FLG_N] = result_i[WIDTH-1];
    raw[FLG_V] = result_i[WIDTH-1] ^ carry_i;
    raw[FLG_H] = half_i;
  end

  always_comb begin
    if (is_left_i)       we_o = WE_LEFT;
    else if (is_right_i) we_o = WE_RIGHT;
    else                 we_o = WE_NONE;
  end

  // disabled flags read as zero
  assign flags_o = raw & we_o;
endmodule

// File: rtl/shift_out_reg.sv
module shift_out_reg
  import shift_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [WIDTH-1:0]     result_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] we_i,
  output logic                 valid_o,
  output logic [WIDTH-1:0]     result_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
      we_o     <= '0;
    end else begin
      valid_o <= valid_i;
      we_o    <= valid_i ? we_i : '0;
      if (valid_i) begin
        result_o <= result_i;
        flags_o  <= flags_i;
      end
    end
  end
endmodule

// File: rtl/byte_shift_unit.sv
module byte_shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [WIDTH-1:0]     operand_i,
  input  logic                 carry_i,
  output logic                 valid_o,
  output logic [WIDTH-1:0]     result_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] flag_we_o
);
  logic [WIDTH-1:0]     dp_result;
  logic                 dp_carry;
  logic                 dp_half;
  logic                 dp_left;
  logic                 dp_right;
  logic [NUM_FLAGS-1:0] fl_val;
  logic [NUM_FLAGS-1:0] fl_we;

  shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .op_i       (op_i),
    .operand_i  (operand_i),
    .carry_i    (carry_i),
    .result_o   (dp_result),
    .carry_o    (dp_carry),
    .half_o     (dp_half),
    .is_left_o  (dp_left),
    .is_right_o (dp_right)
  );

  shift_flags #(.WIDTH(WIDTH)) u_flags (
    .result_i   (dp_result),
    .carry_i    (dp_carry),
    .half_i     (dp_half),
    .is_left_i  (dp_left),
    .is_right_i (dp_right),
    .flags_o    (fl_val),
    .we_o       (fl_we)
  );

  shift_out_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .result_i (dp_result),
    .flags_i  (fl_val),
    .we_i     (fl_we),
    .valid_o  (valid_o),
    .result_o (result_o),
    .flags_o  (flags_o),
    .we_o     (flag_we_o)
  );
endmodule

// File: rtl/byte_shift_unit_chk.sv
module byte_shift_unit_chk
  import shift_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [2:0]           op_i,
  input logic [WIDTH-1:0]     operand_i,
  input logic                 carry_i,
  input logic                 valid_o,
  input logic [WIDTH-1:0]     result_o,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic [NUM_FLAGS-1:0] flag_we_o
);
  localparam int unsigned HALF = WIDTH / 2;

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r2_shl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd0) |=>
      (result_o == {$past(operand_i[WIDTH-2:0]), 1'b0}) &&
      (flags_o[FLG_C] == $past(operand_i[WIDTH-1])));

  a_r5_rotr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=>
      (result_o == {$past(carry_i), $past(operand_i[WIDTH-1:1])}));

  a_r6_sar_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd4) |=> (result_o[WIDTH-1] == $past(operand_i[WIDTH-1])));

  a_r7_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd5) |=>
      (flag_we_o == '0) && (result_o == {$past(operand_i[HALF-1:0]), $past(operand_i[WIDTH-1:HALF])}));

  a_r8_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_we_o[FLG_Z]) |-> (flags_o[FLG_Z] == (result_o == '0)));

  a_r8_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && flag_we_o[FLG_V]) |-> (flags_o[FLG_V] == (result_o[WIDTH-1] ^ flags_o[FLG_C])));

  a_r10_masked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~flag_we_o) == '0 || !valid_o);

  a_r11_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2:1] == 2'b11) |=> (result_o == $past(operand_i)) && (flag_we_o == '0));

  a_r12_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && (flag_we_o == '0) && $stable(result_o) && $stable(flags_o));
endmodule

bind byte_shift_unit byte_shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .operand_i (operand_i),
  .carry_i   (carry_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .flags_o   (flags_o),
  .flag_we_o (flag_we_o)
);

// File: tb/byte_shift_unit_tb.sv
module byte_shift_unit_tb;
  localparam logic [2:0] C_SHL = 3'd0, C_SHR = 3'd1, C_ROTL = 3'd2,
                         C_ROTR = 3'd3, C_SAR = 3'd4, C_SWAP = 3'd5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       carry_i = 1'b0;
  logic       valid_o;
  logic [7:0] result_o;
  logic [4:0] flags_o;
  logic [4:0] flag_we_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  byte_shift_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .carry_i(carry_i), .valid_o(valid_o),
    .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // reference built from the requirements; flags {H,V,N,Z,C}
  task automatic model(input logic [2:0] op, input logic [7:0] a, input logic cin,
                       output logic [7:0] res, output logic [4:0] fl, output logic [4:0] we);
    logic c;
    c = 1'b0;
    we = 5'b00000;
    res = a;
    case (op)
      C_SHL:  begin res = {a[6:0], 1'b0}; c = a[7]; we = 5'b11111; end
      C_ROTL: begin res = {a[6:0], cin};  c = a[7]; we = 5'b11111; end
      C_SHR:  begin res = {1'b0, a[7:1]}; c = a[0]; we = 5'b01111; end
      C_ROTR: begin res = {cin, a[7:1]};  c = a[0]; we = 5'b01111; end
      C_SAR:  begin res = {a[7], a[7:1]}; c = a[0]; we = 5'b01111; end
      C_SWAP: res = {a[3:0], a[7:4]};
      default: res = a;
    endcase
    fl = {a[3], res[7] ^ c, res[7], (res == 8'h00), c} & we;
  endtask

  // call at a negedge; drives one request, checks it at the following negedge
  task automatic apply(string tag, logic [2:0] op, logic [7:0] a, logic cin);
    logic [7:0] er;
    logic [4:0] ef, ew;
    model(op, a, cin, er, ef, ew);
    valid_i = 1'b1; op_i = op; operand_i = a; carry_i = cin;
    @(negedge clk_i);
    check({tag, " valid R1"}, {7'd0, valid_o}, 8'd1);
    check({tag, " result"}, result_o, er);
    check({tag, " flags R8"}, {3'd0, flags_o}, {3'd0, ef});
    check({tag, " mask R10"}, {3'd0, flag_we_o}, {3'd0, ew});
  endtask

  task automatic idle_check(string tag);
    logic [7:0] r;
    logic [4:0] f;
    r = result_o; f = flags_o;
    valid_i = 1'b0; operand_i = ~operand_i; op_i = C_SHL;
    @(negedge clk_i);
    check({tag, " R12 valid"}, {7'd0, valid_o}, 8'd0);
    check({tag, " R12 mask"}, {3'd0, flag_we_o}, 8'd0);
    check({tag, " R12 result"}, result_o, r);
    check({tag, " R12 flags"}, {3'd0, flags_o}, {3'd0, f});
  endtask

  task automatic t_reset();
    check("R1 reset valid", {7'd0, valid_o}, 8'd0);
    check("R1 reset result", result_o, 8'd0);
    check("R1 reset flags", {3'd0, flags_o}, 8'd0);
    check("R1 reset mask", {3'd0, flag_we_o}, 8'd0);
  endtask

  task automatic t_shl();
    apply("R2 shl 80", C_SHL, 8'h80, 1'b1);
    check("R2 shl 80 zero-carry-ovf", {3'd0, flags_o}, 8'h0B);
    apply("R2 shl 4c", C_SHL, 8'h4C, 1'b0);
    apply("R9 shl h", C_SHL, 8'h08, 1'b1);
    check("R9 shl half", {7'd0, flags_o[4]}, 8'd1);
    idle_check("shl");
  endtask

  task automatic t_shr();
    apply("R3 shr 01", C_SHR, 8'h01, 1'b1);
    check("R3 shr 01 flags", {3'd0, flags_o}, 8'h0B);
    apply("R3 shr fe", C_SHR, 8'hFE, 1'b1);
    idle_check("shr");
  endtask

  task automatic t_rotl();
    apply("R4 rotl 80 c1", C_ROTL, 8'h80, 1'b1);
    check("R4 rotl result", result_o, 8'h01);
    apply("R4 rotl 80 c0", C_ROTL, 8'h80, 1'b0);
    apply("R4 rotl 7f c1", C_ROTL, 8'h7F, 1'b1);
    idle_check("rotl");
  endtask

  task automatic t_rotr();
    apply("R5 rotr 01 c1", C_ROTR, 8'h01, 1'b1);
    check("R5 rotr result", result_o, 8'h80);
    apply("R5 rotr 01 c0", C_ROTR, 8'h01, 1'b0);
    apply("R9 rotr 08 no h", C_ROTR, 8'h08, 1'b0);
    check("R9 rotr h off", {7'd0, flag_we_o[4]}, 8'd0);
  endtask

  task automatic t_sar();
    apply("R6 sar 81", C_SAR, 8'h81, 1'b0);
    check("R6 sar 81 flags", {3'd0, flags_o}, 8'h05);
    apply("R6 sar 40", C_SAR, 8'h40, 1'b1);
    apply("R6 sar 01", C_SAR, 8'h01, 1'b0);
  endtask

  task automatic t_swap();
    apply("R7 swap a5", C_SWAP, 8'hA5, 1'b1);
    check("R7 swap result", result_o, 8'h5A);
    apply("R7 swap 00", C_SWAP, 8'h00, 1'b0);
    idle_check("swap");
  endtask

  task automatic t_reserved();
    apply("R11 op6", 3'd6, 8'h3C, 1'b1);
    apply("R11 op7", 3'd7, 8'h00, 1'b1);
    idle_check("reserved");
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 6; k++) begin
        apply($sformatf("R10 sweep op%0d", op), op[2:0], 8'(k * 53 + 7), k[0]);
      end
    end
    idle_check("sweep");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_shl();
    t_shr();
    t_rotl();
    t_rotr();
    t_sar();
    t_swap();
    t_reserved();
    t_sweep();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule